// File: doc/BRIEF.md
# Side-Effect Control Register File

This block is the control register bank of a command-processor microcontroller. The processor writes 32-bit words into a small array of registers through a plain write port and reads any register back through a combinational read port. Most registers just hold what was written. A few "data" registers have a side effect: a write to them pushes the word out through a streaming path whose target address lives in a companion pointer register. That pointer register advances on its own after each push, so firmware can load a pointer once and then stream a run of words.

There are three streaming paths. The table path fills an on-block jump-table RAM. The register-bus path emits a write request to an external GPU register bus. Only the low address bits of its pointer form the offset; the upper bits are flags that never change. The memory path emits a 32-bit write request at a 64-bit byte address held in two adjacent registers. Both outbound paths use valid/ready handshakes. A request is held steady until the consumer takes it. While either request is pending, the register file stalls all writes: `wr_stall` is high and any write offered in that cycle is ignored, so the processor must hold its write until `wr_stall` falls. Every register has a written flag that is set by any write to it, including a pointer advance.

Top module: `sfx_creg_file`

## Requirements
- R1: A write is accepted in a cycle where `wr_en` is 1 and `wr_stall` is 0. After the clock edge the register at `wr_idx` holds `wr_data`, and `rd_data` shows register `rd_idx` combinationally.
- R2: Reset clears every written flag. An accepted write sets the flag of the addressed register. A pointer advance caused by a side effect also sets the flag of each pointer register it changes.
- R3: A write to register 3 (table data) while register 2 (table index) is below the table depth (32) stores the word in the jump table at that index, and register 2 increases by 1. `jt_rd_data` shows entry `jt_rd_idx`.
- R4: A write to register 3 while register 2 is at or above the table depth sets `jt_err`, which stays 1 until reset. The table and register 2 are unchanged.
- R5: A write to register 5 (bus data) raises `gpu_valid` after the edge. `gpu_addr` then equals bits [15:0] of register 4 as it was before the write, and `gpu_data` equals the word.
- R6: After a register 5 write, bits [15:0] of register 4 increase by 1 and wrap from 0xFFFF to 0. Bits [31:16] are kept.
- R7: A write to register 8 (memory data) raises `mem_valid` after the edge. `mem_addr` then equals {register 7, register 6} as it was before the write, with register 6 as the low half, and `mem_data` equals the word.
- R8: After a register 8 write, the 64-bit value {register 7, register 6} increases by 4 in the same cycle, with the carry going from register 6 into register 7.
- R9: A raised request keeps its valid, address and data unchanged until its ready is 1 at a clock edge, and it drops after that edge. `wr_stall` is 1 exactly while a request is valid, and a write offered while `wr_stall` is 1 changes no register, flag or request.
- R10: After reset all registers read 0, `gpu_valid`, `mem_valid` and `jt_err` are 0, and `wr_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write word |
| wr_stall | output | 1 | Writes are ignored while high |
| rd_idx | input | 4 | Register index for the read |
| rd_data | output | 32 | Content of register rd_idx |
| written | output | 16 | Per-register written flags |
| jt_rd_idx | input | 5 | Jump-table read index |
| jt_rd_data | output | 32 | Jump-table entry at jt_rd_idx |
| jt_err | output | 1 | Sticky out-of-range table write flag |
| gpu_valid | output | 1 | Register-bus write request valid |
| gpu_ready | input | 1 | Register-bus consumer ready |
| gpu_addr | output | 16 | Register-bus write offset |
| gpu_data | output | 32 | Register-bus write word |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory consumer ready |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 32 | Memory write word |

## Verification
The hardest cases to reach from the ports are the pointer edges: the register-bus offset wrapping at 0xFFFF with flag bits set above it, the memory address crossing a 32-bit boundary, and a table index walking past the end of the table. The stimulus loads each pointer just below its edge and then streams three words through it. A write that is offered while a request is held by a low ready is a second hard case. The bench forces this by holding ready low, keeping the write strobe high for several cycles, and reading the target register back afterwards. A long phase of mixed writes with irregular ready patterns is compared against a behavioural model on every clock.

// File: rtl/sfx_creg_pkg.sv
package sfx_creg_pkg;
  typedef logic [31:0] word_t;

  // Register indices whose position the side effects depend on
  localparam int unsigned K_TBL_IDX  = 2;
  localparam int unsigned K_TBL_WORD = 3;
  localparam int unsigned K_RB_PTR   = 4;
  localparam int unsigned K_RB_WORD  = 5;
  localparam int unsigned K_MW_LO    = 6;
  localparam int unsigned K_MW_HI    = 7;   // must be K_MW_LO + 1
  localparam int unsigned K_MW_WORD  = 8;
  localparam int unsigned K_MIN_REGS = 9;

  localparam logic [63:0] MW_STEP = 64'd4;
endpackage

// File: rtl/sfx_creg_jtab.sv
module sfx_creg_jtab #(
  parameter int DEPTH = 32,
  localparam int JW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [31:0]   wr_index,
  input  logic [31:0]   wr_word,
  input  logic [JW-1:0] rd_index,
  output logic [31:0]   rd_word,
  output logic          hit,
  output logic          err
);
  logic [31:0] mem [DEPTH];

  assign hit     = wr_index < 32'(DEPTH);
  assign rd_word = mem[rd_index];

  always_ff @(posedge clk) begin
    if (wr_req && hit) mem[wr_index[JW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               err <= 1'b0;
    else if (wr_req && !hit)  err <= 1'b1;
  end

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_err_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !hit) |=> err);
endmodule

// File: rtl/sfx_creg_req.sv
module sfx_creg_req #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_payload,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] payload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      payload <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      payload <= load_payload;
    end else if (valid && ready) begin
      valid   <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(payload)));
  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);
endmodule

// File: rtl/sfx_creg_file.sv
module sfx_creg_file
  import sfx_creg_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int JT_DEPTH = 32,
  parameter int GPU_AW   = 16,
  localparam int IW = $clog2(NREG),
  localparam int JW = $clog2(JT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [31:0]       wr_data,
  output logic              wr_stall,
  input  logic [IW-1:0]     rd_idx,
  output logic [31:0]       rd_data,
  output logic [NREG-1:0]   written,
  input  logic [JW-1:0]     jt_rd_idx,
  output logic [31:0]       jt_rd_data,
  output logic              jt_err,
  output logic              gpu_valid,
  input  logic              gpu_ready,
  output logic [GPU_AW-1:0] gpu_addr,
  output logic [31:0]       gpu_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [63:0]       mem_addr,
  output logic [31:0]       mem_data
);
  localparam int GW = GPU_AW + 32;
  localparam int MW = 64 + 32;

  word_t           regs     [NREG];
  word_t           regs_nxt [NREG];
  logic [NREG-1:0] wflag_nxt;

  logic acc, sel_tbl, sel_rb, sel_mw, jt_hit;
  word_t tbl_ptr, rb_ptr, rb_ptr_next;
  logic [63:0] mw_ptr, mw_ptr_next;
  logic [GW-1:0] gpu_pl;
  logic [MW-1:0] mem_pl;

  assign wr_stall = gpu_valid | mem_valid;
  assign acc      = wr_en && !wr_stall && (int'(wr_idx) < NREG);
  assign sel_tbl  = acc && (wr_idx == IW'(K_TBL_WORD));
  assign sel_rb   = acc && (wr_idx == IW'(K_RB_WORD));
  assign sel_mw   = acc && (wr_idx == IW'(K_MW_WORD));

  assign tbl_ptr     = regs[K_TBL_IDX];
  assign rb_ptr      = regs[K_RB_PTR];
  assign rb_ptr_next = {rb_ptr[31:GPU_AW], rb_ptr[GPU_AW-1:0] + GPU_AW'(1)};
  assign mw_ptr      = {regs[K_MW_HI], regs[K_MW_LO]};
  assign mw_ptr_next = mw_ptr + MW_STEP;

  always_comb begin
    regs_nxt  = regs;
    wflag_nxt = written;
    if (acc) begin
      regs_nxt[wr_idx]  = wr_data;
      wflag_nxt[wr_idx] = 1'b1;
    end
    if (sel_tbl && jt_hit) begin
      regs_nxt[K_TBL_IDX]  = tbl_ptr + 32'd1;
      wflag_nxt[K_TBL_IDX] = 1'b1;
    end
    if (sel_rb) begin
      regs_nxt[K_RB_PTR]  = rb_ptr_next;
      wflag_nxt[K_RB_PTR] = 1'b1;
    end
    if (sel_mw) begin
      regs_nxt[K_MW_LO]  = mw_ptr_next[31:0];
      regs_nxt[K_MW_HI]  = mw_ptr_next[63:32];
      wflag_nxt[K_MW_LO] = 1'b1;
      wflag_nxt[K_MW_HI] = 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i]    <= '0;
        written[i] <= 1'b0;
      end else begin
        regs[i]    <= regs_nxt[i];
        written[i] <= wflag_nxt[i];
      end
    end
  end

  assign rd_data = regs[rd_idx];

  sfx_creg_jtab #(.DEPTH(JT_DEPTH)) u_jtab (
    .clk(clk), .rst_n(rst_n), .wr_req(sel_tbl), .wr_index(tbl_ptr),
    .wr_word(wr_data), .rd_index(jt_rd_idx), .rd_word(jt_rd_data),
    .hit(jt_hit), .err(jt_err)
  );

  sfx_creg_req #(.W(GW)) u_gpu_req (
    .clk(clk), .rst_n(rst_n), .load(sel_rb),
    .load_payload({rb_ptr[GPU_AW-1:0], wr_data}),
    .valid(gpu_valid), .ready(gpu_ready), .payload(gpu_pl)
  );
  assign gpu_addr = gpu_pl[GW-1:32];
  assign gpu_data = gpu_pl[31:0];

  sfx_creg_req #(.W(MW)) u_mem_req (
    .clk(clk), .rst_n(rst_n), .load(sel_mw),
    .load_payload({mw_ptr, wr_data}),
    .valid(mem_valid), .ready(mem_ready), .payload(mem_pl)
  );
  assign mem_addr = mem_pl[MW-1:32];
  assign mem_data = mem_pl[31:0];

  assert_tbl_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tbl && jt_hit) |=> regs[K_TBL_IDX] == $past(regs[K_TBL_IDX]) + 32'd1);
  assert_tbl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tbl && !jt_hit) |=> $stable(regs[K_TBL_IDX]));
  assert_flags_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rb |=> regs[K_RB_PTR][31:GPU_AW] == $past(regs[K_RB_PTR][31:GPU_AW]));
  assert_gpu_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rb |=> gpu_valid && gpu_data == $past(wr_data));
  assert_mw_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_mw |=> {regs[K_MW_HI], regs[K_MW_LO]} == $past({regs[K_MW_HI], regs[K_MW_LO]}) + MW_STEP);
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |=> $stable(written));
  assert_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> written[$past(wr_idx)]);

  initial begin
    assert (NREG >= int'(K_MIN_REGS)) else $error("NREG too small");
  end
endmodule

// File: tb/tb_sfx_creg_file.sv
module tb_sfx_creg_file;
  localparam int TBL_IDX = 2, TBL_WORD = 3, RB_PTR = 4, RB_WORD = 5;
  localparam int MW_LO = 6, MW_HI = 7, MW_WORD = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [3:0] wr_idx = 0; logic [31:0] wr_data = 0;
  logic wr_stall; logic [3:0] rd_idx = 0; logic [31:0] rd_data;
  logic [15:0] written; logic [4:0] jt_rd_idx = 0; logic [31:0] jt_rd_data;
  logic jt_err, gpu_valid, mem_valid; logic gpu_ready = 1, mem_ready = 1;
  logic [15:0] gpu_addr; logic [31:0] gpu_data, mem_data; logic [63:0] mem_addr;

  always #4 clk = ~clk;

  sfx_creg_file dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_stall(wr_stall), .rd_idx(rd_idx), .rd_data(rd_data), .written(written),
    .jt_rd_idx(jt_rd_idx), .jt_rd_data(jt_rd_data), .jt_err(jt_err),
    .gpu_valid(gpu_valid), .gpu_ready(gpu_ready), .gpu_addr(gpu_addr), .gpu_data(gpu_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // Behavioural reference model
  logic [31:0] mr [16]; bit mw [16]; logic [31:0] mjt [32]; bit mknown [32];
  bit merr, mgv, mmv, m_last_acc; logic [15:0] mga; logic [31:0] mgd, mmd; logic [63:0] mma;
  int errors = 0, checks = 0, cycles = 0, ready_mode = 0, sweep = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mr[i] = 0; mw[i] = 0; end
      for (int i = 0; i < 32; i++) mknown[i] = 0;
      merr = 0; mgv = 0; mmv = 0; m_last_acc = 0;
    end else begin
      bit acc; logic [63:0] a;
      acc = wr_en && !(mgv || mmv);
      if (mgv && gpu_ready) mgv = 0;
      if (mmv && mem_ready) mmv = 0;
      m_last_acc = acc;
      if (acc) begin
        mr[wr_idx] = wr_data; mw[wr_idx] = 1;
        if (wr_idx == TBL_WORD) begin
          if (mr[TBL_IDX] < 32) begin
            mjt[mr[TBL_IDX]] = wr_data; mknown[mr[TBL_IDX]] = 1;
            mr[TBL_IDX] = mr[TBL_IDX] + 1; mw[TBL_IDX] = 1;
          end else merr = 1;
        end else if (wr_idx == RB_WORD) begin
          mga = mr[RB_PTR][15:0]; mgd = wr_data; mgv = 1;
          mr[RB_PTR] = {mr[RB_PTR][31:16], mr[RB_PTR][15:0] + 16'd1}; mw[RB_PTR] = 1;
        end else if (wr_idx == MW_WORD) begin
          a = {mr[MW_HI], mr[MW_LO]}; mma = a; mmd = wr_data; mmv = 1;
          a = a + 64'd4; mr[MW_LO] = a[31:0]; mr[MW_HI] = a[63:32];
          mw[MW_LO] = 1; mw[MW_HI] = 1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [15:0] wexp;
    @(negedge clk);
    rd_idx = 4'(sweep); jt_rd_idx = 5'(sweep); sweep++;
    #1;
    chk("R1 rd_data", rd_data, mr[rd_idx]);
    for (int i = 0; i < 16; i++) wexp[i] = mw[i];
    chk("R2 written", written, wexp);
    if (mknown[jt_rd_idx]) chk("R3 jt_rd_data", jt_rd_data, mjt[jt_rd_idx]);
    chk("R4 jt_err", jt_err, merr);
    chk("R9 wr_stall", wr_stall, mgv || mmv);
    chk("R5 gpu_valid", gpu_valid, mgv);
    if (mgv) begin chk("R5 gpu_addr", gpu_addr, mga); chk("R5 gpu_data", gpu_data, mgd); end
    chk("R7 mem_valid", mem_valid, mmv);
    if (mmv) begin chk("R7 mem_addr", mem_addr, mma); chk("R7 mem_data", mem_data, mmd); end
    case (ready_mode)
      0: begin gpu_ready = 1; mem_ready = 1; end
      1: begin gpu_ready = ($urandom % 3) != 0; mem_ready = ($urandom % 3) != 0; end
      default: begin gpu_ready = 0; mem_ready = 0; end
    endcase
  endtask

  task automatic wr(int idx, logic [31:0] d);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    do tick(); while (!m_last_acc);
    wr_en = 0;
  endtask

  task automatic peek(int idx, logic [31:0] exp, string tag);
    rd_idx = 4'(idx); #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R10: reset state
    for (int i = 0; i < 16; i++) peek(i, 32'h0, "R10 reset reg");
    chk("R10 written", written, 16'h0);
    chk("R10 valids", {gpu_valid, mem_valid, jt_err, wr_stall}, 4'b0);

    wr(1, 32'h1111_1111); wr(0, 32'hDEAD_BEEF); wr(15, 32'h0F0F_0F0F);
    tick(); peek(15, 32'h0F0F_0F0F, "R1 plain store");

    // R3/R4: table near its end
    wr(TBL_IDX, 30); wr(TBL_WORD, 32'hA0A0_0030); wr(TBL_WORD, 32'hA0A0_0031);
    tick(); peek(TBL_IDX, 32, "R3 index step");
    jt_rd_idx = 5'd31; #1; chk("R3 table entry 31", jt_rd_data, 32'hA0A0_0031);
    wr(TBL_WORD, 32'hBAD0_BAD0);
    tick(); peek(TBL_IDX, 32, "R4 index unchanged");
    chk("R4 err raised", jt_err, 1'b1);
    wr(TBL_IDX, 0); wr(TBL_WORD, 32'h1234_0000);
    tick(); chk("R4 err sticky", jt_err, 1'b1);

    // R5/R6: register-bus offset wrap with flags
    wr(RB_PTR, 32'hABCD_FFFE); wr(RB_WORD, 32'h5000_0001);
    chk("R5 first offset", {gpu_valid, gpu_addr}, {1'b1, 16'hFFFE});
    wr(RB_WORD, 32'h5000_0002); wr(RB_WORD, 32'h5000_0003);
    chk("R6 wrapped offset", gpu_addr, 16'h0000);
    tick(); peek(RB_PTR, 32'hABCD_0001, "R6 flags kept");

    // R7/R8: memory address carry
    wr(MW_LO, 32'hFFFF_FFF8); wr(MW_HI, 32'h12); wr(MW_WORD, 32'h7000_0001);
    chk("R7 first address", mem_addr, 64'h12_FFFF_FFF8);
    wr(MW_WORD, 32'h7000_0002); wr(MW_WORD, 32'h7000_0003);
    chk("R8 crossed address", mem_addr, 64'h13_0000_0000);
    tick(); peek(MW_LO, 32'h4, "R8 low half"); peek(MW_HI, 32'h13, "R8 high half");

    // R9: writes offered while a request is held
    ready_mode = 2; tick();
    wr(RB_WORD, 32'h0000_0055);
    wr_en = 1; wr_idx = 4'd1; wr_data = 32'h2222_2222;
    repeat (4) begin tick(); chk("R9 stall held", {wr_stall, gpu_valid}, 2'b11); end
    wr_en = 0; ready_mode = 0;
    repeat (2) tick();
    peek(1, 32'h1111_1111, "R9 ignored write");

    // Mixed traffic with irregular ready
    ready_mode = 1;
    for (int n = 0; n < 600; n++) begin
      int k; logic [31:0] d;
      k = $urandom % 8; d = $urandom;
      case (k)
        0: wr(TBL_IDX, d % 40);
        1, 2: wr(TBL_WORD, d);
        3: wr(RB_WORD, d);
        4: wr(MW_WORD, d);
        default: wr($urandom % 16, d);
      endcase
    end
    ready_mode = 0;
    repeat (4) tick();
    summary();
  end
endmodule